// File: doc/BRIEF.md
# External Interrupt Pin Trigger Detector

This block watches a parameterised set of external interrupt pins (16 by default) and turns each pin into an event request. Each pin has its own control word on a simple word-addressed register bus. The two low bits of that word pick one of four trigger rules: falling edge, rising edge, either edge, or active-low level. Each pin input passes through a two-flop synchroniser. The block keeps the last synchronised level of every pin and compares it with the current level on every clock.

The requests leave on an event vector whose bit 0 stands for "no event" and is never raised. Pin k drives event bit k+1. When software writes a pin's control word, that pin is checked again in the same cycle under the newly written rule against its stored level. A switch to low-level mode on a pin that already sits low therefore raises the request on the next clock edge. The noise filter enable and the filter clock select fields are kept and read back, but they have no effect on behaviour.

Top module: `pin_trigger_detect`

## Requirements
- R1: After reset every event output is 0 and every pin control word reads back 0, which selects falling-edge mode.
- R2: In mode 0 (falling edge) a pin raises its event for exactly one cycle after a 1-to-0 transition, and never on a 0-to-1 transition.
- R3: In mode 1 (rising edge) a pin raises its event for exactly one cycle after a 0-to-1 transition, and never on a 1-to-0 transition.
- R4: In mode 2 (both edges) a pin raises its event for one cycle after every change of its level.
- R5: In mode 3 (low level) a pin's event stays high on every cycle for which its synchronised level is 0.
- R6: Pin k (from 0) drives bit k+1 of `event_o`; bit 0 is the "no event" number and is always 0, and a pin's activity touches no other bit.
- R7: The control word of pin k is at byte offset 4*k. Bits [1:0] select the mode, bits [5:4] and bit 7 are stored and read back with no effect on triggering, and all other bits read as 0 (writing all ones reads back 0x000000B3).
- R8: A write to a pin's control word evaluates that pin in the write cycle under the written mode against its stored level, so the event reflects the new mode on the first clock edge after the write.
- R9: Writes to word indexes at or beyond the number of pins change no control word, and reads there return 0.
- R10: A pin change reaches `event_o` on the third rising clock edge after it is applied (two synchroniser stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | ADDR_W | Byte address of the control word (bits [1:0] ignored) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| event_o | output | NUM_PINS+1 | Event requests; bit 0 is "no event", bit k+1 belongs to pin k |

## Verification
Checks that run on every cycle cover the per-pin rules. Low-level mode on a low pin must yield an event on the next cycle, and an edge mode with an unchanged level must yield none. Both-edges mode must fire on any change. A write that selects low level on a low pin must fire. Each accepted write must land in the addressed control word, and an out-of-range write must leave all words unchanged. The exact cycle of the synchroniser latency, the one-cycle width of edge pulses, the isolation of each event bit and the read-back masking of the filter and reserved bits can only be shown by the directed scenarios. The same holds for the timing difference that the write re-evaluation makes.

// File: rtl/pin_trig_pkg.sv
package pin_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_FALL = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_BOTH = 2'd2,
    TRIG_LOW  = 2'd3
  } trig_mode_e;

  // stored per-pin control; filter fields are inert
  typedef struct packed {
    logic       flt_en;
    logic [1:0] flt_clk;
    trig_mode_e mode;
  } pin_ctrl_t;

  localparam int MODE_LSB   = 0;
  localparam int FCLK_LSB   = 4;
  localparam int FLTEN_BIT  = 7;
  localparam int CTRL_W     = 32;

  function automatic logic eval_trig(trig_mode_e m, logic prev, logic cur);
    logic hit;
    case (m)
      TRIG_FALL: hit = prev & ~cur;
      TRIG_RISE: hit = ~prev & cur;
      TRIG_BOTH: hit = prev ^ cur;
      default:   hit = ~cur;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= '0;
      else         st_q <= {st_q[STAGES-2:0], pin_i[g]};
    end
    assign lvl_o[g] = st_q[STAGES-1];
  end

endmodule

// File: rtl/pin_trig_eval.sv
module pin_trig_eval
  import pin_trig_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  trig_mode_e mode_i,
  input  logic       wr_i,
  input  trig_mode_e wr_mode_i,
  output logic       trig_o
);

  logic       prev_q;
  logic       trig_q;
  trig_mode_e eff_mode;

  // a write re-checks the pin under the incoming mode
  assign eff_mode = wr_i ? wr_mode_i : mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      trig_q <= eval_trig(eff_mode, prev_q, lvl_i);
    end
  end

  assign trig_o = trig_q;

  AST_LOW_LEVEL_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_LOW && !wr_i && !lvl_i) |=> trig_o); // R5

  AST_NO_EDGE_NO_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != TRIG_LOW && !wr_i && prev_q == lvl_i) |=> !trig_o); // R2

  AST_BOTH_EDGE_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIG_BOTH && !wr_i && prev_q != lvl_i) |=> trig_o); // R4

  AST_WRITE_REEVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_mode_i == TRIG_LOW && !lvl_i) |=> trig_o); // R8

endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
  import pin_trig_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [CTRL_W-1:0]         wdata_i,
  output logic [CTRL_W-1:0]         rdata_o,
  output logic [NUM_PINS-1:0][1:0]  mode_o,
  output logic [NUM_PINS-1:0]       wr_stb_o,
  output logic [1:0]                wr_mode_o
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W:0] PIN_LIM = (IDX_W+1)'(NUM_PINS);

  pin_ctrl_t [NUM_PINS-1:0] ctrl_q;
  logic [IDX_W-1:0]         idx;
  logic                     hit;

  assign idx = addr_i[ADDR_W-1:2];
  assign hit = ({1'b0, idx} < PIN_LIM);
  assign wr_mode_o = wdata_i[MODE_LSB +: 2];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_reg
    assign wr_stb_o[i] = wr_en_i && hit && (idx == IDX_W'(i));
    assign mode_o[i]   = ctrl_q[i].mode;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[i] <= '0;
      end else if (wr_stb_o[i]) begin
        ctrl_q[i].mode    <= trig_mode_e'(wdata_i[MODE_LSB +: 2]);
        ctrl_q[i].flt_clk <= wdata_i[FCLK_LSB +: 2];
        ctrl_q[i].flt_en  <= wdata_i[FLTEN_BIT];
      end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stb_o[i] |=> ctrl_q[i] == {$past(wdata_i[FLTEN_BIT]),
                                     $past(wdata_i[FCLK_LSB +: 2]),
                                     $past(wdata_i[MODE_LSB +: 2])}); // R7
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        if (idx == IDX_W'(i)) begin
          rdata_o[MODE_LSB +: 2] = ctrl_q[i].mode;
          rdata_o[FCLK_LSB +: 2] = ctrl_q[i].flt_clk;
          rdata_o[FLTEN_BIT]     = ctrl_q[i].flt_en;
        end
      end
    end
  end

  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(ctrl_q)); // R9

endmodule

// File: rtl/pin_trigger_detect.sv
module pin_trigger_detect
  import pin_trig_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic [NUM_PINS:0]   event_o
);

  logic [NUM_PINS-1:0]      lvl;
  logic [NUM_PINS-1:0][1:0] mode;
  logic [NUM_PINS-1:0]      wr_stb;
  logic [1:0]               wr_mode;
  logic [NUM_PINS-1:0]      trig;

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl)
  );

  pin_ctrl_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .mode_o    (mode),
    .wr_stb_o  (wr_stb),
    .wr_mode_o (wr_mode)
  );

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    pin_trig_eval i_eval (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lvl_i     (lvl[k]),
      .mode_i    (trig_mode_e'(mode[k])),
      .wr_i      (wr_stb[k]),
      .wr_mode_i (trig_mode_e'(wr_mode)),
      .trig_o    (trig[k])
    );
  end

  // event number 0 is reserved for "no event"
  assign event_o = {trig, 1'b0};

endmodule

// File: tb/test_pin_trigger_detect.sv
module test_pin_trigger_detect;

  localparam int NP = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP:0]   event_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pin_trigger_detect #(.NUM_PINS(NP), .ADDR_W(AW)) i_pin_trigger_detect (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .pin_i   (pins),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .event_o (event_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_pin(input int k, input logic v);
    @(negedge clk);
    pins[k] = v;
  endtask

  // pulse on third edge, exactly one cycle, only bit k+1
  task automatic expect_pulse(input int k, input string req);
    logic [NP:0] exp;
    exp = (NP+1)'(1) << (k + 1);
    repeat (2) @(negedge clk);
    chk(event_o[k+1] == 1'b0, {req, " R10 early"}, 32'(event_o[k+1]), 0);
    @(negedge clk);
    chk(event_o == exp, {req, " R6 pulse"}, 32'(event_o), 32'(exp));
    @(negedge clk);
    chk(event_o[k+1] == 1'b0, {req, " one cycle"}, 32'(event_o[k+1]), 0);
  endtask

  task automatic expect_none(input int k, input string req);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(event_o[k+1] == 1'b0, req, 32'(event_o[k+1]), 0);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk(event_o == '0, "R1 events", 32'(event_o), 0);
    reg_rd(12'h000, d); chk(d == 0, "R1 pin0 word", d, 0);
    reg_rd(12'h03C, d); chk(d == 0, "R1 pin15 word", d, 0);
  endtask

  task automatic t_fall;
    set_pin(0, 1'b1); expect_none(0, "R2 no rise");
    set_pin(0, 1'b0); expect_pulse(0, "R2 fall");
  endtask

  task automatic t_rise;
    reg_wr(12'h008, 32'h1);
    set_pin(2, 1'b1); expect_pulse(2, "R3 rise");
    set_pin(2, 1'b0); expect_none(2, "R3 no fall");
  endtask

  task automatic t_both;
    reg_wr(12'h00C, 32'h2);
    set_pin(3, 1'b1); expect_pulse(3, "R4 up");
    set_pin(3, 1'b0); expect_pulse(3, "R4 down");
  endtask

  task automatic t_low;
    reg_wr(12'h014, 32'h3);
    chk(event_o[6] == 1'b1, "R8 reeval low", 32'(event_o[6]), 1);
    chk(event_o[0] == 1'b0, "R6 bit0", 32'(event_o[0]), 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(event_o[6] == 1'b1, "R5 hold", 32'(event_o[6]), 1);
    end
    set_pin(5, 1'b1);
    repeat (2) @(negedge clk);
    chk(event_o[6] == 1'b1, "R10 low lag", 32'(event_o[6]), 1);
    @(negedge clk);
    chk(event_o[6] == 1'b0, "R5 released", 32'(event_o[6]), 0);
    set_pin(5, 1'b0);
    repeat (3) @(negedge clk);
    chk(event_o[6] == 1'b1, "R5 low again", 32'(event_o[6]), 1);
    reg_wr(12'h014, 32'h0);
    chk(event_o[6] == 1'b0, "R8 reeval fall", 32'(event_o[6]), 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    reg_wr(12'h010, 32'hFFFF_FFFF);
    reg_rd(12'h010, d); chk(d == 32'hB3, "R7 mask", d, 32'hB3);
    reg_wr(12'h010, 32'hB1);
    chk(event_o[5] == 1'b0, "R8 rise no edge", 32'(event_o[5]), 0);
    reg_rd(12'h010, d); chk(d == 32'hB1, "R7 readback", d, 32'hB1);
    set_pin(4, 1'b1); expect_pulse(4, "R7 filter inert");
    reg_wr(12'h03C, 32'h2);
    reg_rd(12'h03C, d); chk(d == 32'h2, "R7 last pin", d, 32'h2);
  endtask

  task automatic t_oor;
    logic [31:0] d;
    reg_wr(12'h040, 32'h3);
    reg_wr(12'hFFC, 32'hB3);
    reg_rd(12'h040, d); chk(d == 0, "R9 read 0x40", d, 0);
    reg_rd(12'hFFC, d); chk(d == 0, "R9 read 0xFFC", d, 0);
    reg_rd(12'h000, d); chk(d == 0, "R9 no alias", d, 0);
    expect_none(0, "R9 pin0 quiet");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fall();
    t_rise();
    t_both();
    t_low();
    t_regs();
    t_oor();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule